// File: doc/BRIEF.md
# Two-Rank Crosspoint Switch Controller

This block holds the on/off enable of every switch in a crosspoint array of 8 columns by 12 rows, 96 switches in all. A write command carries a 7-bit switch address and a data bit. The address is decoded to one switch position, and the bit is stored in a staging rank. A load command copies the whole staging rank into the output rank in one clock. The output rank drives the switch enables, so a set of routing changes can be prepared one switch at a time and then applied all together.

A write can also carry an immediate-load flag. It then stores its bit and loads the output rank on the same clock edge. An asynchronous active-low reset clears both ranks, which turns every switch off and drops any staged change. A registered readback port returns the applied enable of any addressed switch. The serial bus front end and the analog switch cells sit outside this block.

Top module: `xpt_switch_ctrl`

## Requirements
- R1: Switch index is row × 8 + column, with rows 0–11 and columns 0–7. Bit k of `sw_en` is the applied enable of index k, where 1 means on.
- R2: A write (`wr_valid`=1, `wr_load`=0, `ld_strobe`=0) to address 0–95 stores `wr_data` in the staging bit of that index. `sw_en` does not change on that edge.
- R3: On a clock edge with `ld_strobe`=1, every staging bit is copied to `sw_en` at once, so several switches change on the same edge.
- R4: A write with `wr_load`=1 stores its bit and copies the full staging rank to `sw_en` on the same edge, and this includes the bit just written.
- R5: Any combination of enables may be on together. All 96 may be on at once, with no rule between rows or columns.
- R6: A write to address 96–127 changes no staging bit. Its load part (`wr_load` or `ld_strobe`) still copies the existing staging rank.
- R7: While `rst_n` is low, `sw_en` is 0 without waiting for a clock edge. The staging rank is also cleared, so a load after reset leaves every switch off.
- R8: `rd_data` is registered. After the edge that samples `rd_addr`, it equals the `sw_en` bit of that index as it was before the edge. It is 0 for addresses 96–127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write command strobe |
| wr_addr | input | 7 | Switch address of the write |
| wr_data | input | 1 | Enable value to stage |
| wr_load | input | 1 | Apply the staging rank on the same edge as the write |
| ld_strobe | input | 1 | Copy the staging rank to the output rank |
| rd_addr | input | 7 | Readback switch address |
| rd_data | output | 1 | Registered applied enable of the addressed switch |
| sw_en | output | 96 | Applied switch enables |

## Verification
A staged write shows nothing on `sw_en`. A load, or a write with the immediate flag, shows on `sw_en` right after the edge that takes it, and readback appears one edge after the address is presented. Reset acts on `sw_en` with no edge at all. The bench drives inputs on falling edges and samples at the next falling edge, which is half a period after the edge that takes the command. It checks the whole 96-bit output against a reference model after every step. The reset case is sampled a short delay after `rst_n` falls and before any clock edge.

// File: rtl/xpt_switch_ctrl.sv
module xpt_switch_ctrl #(
  parameter int NCOL = 8,
  parameter int NROW = 12,
  parameter int AW   = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_valid,
  input  logic [AW-1:0]        wr_addr,
  input  logic                 wr_data,
  input  logic                 wr_load,
  input  logic                 ld_strobe,
  input  logic [AW-1:0]        rd_addr,
  output logic                 rd_data,
  output logic [NCOL*NROW-1:0] sw_en
);
  localparam int NSW = NCOL * NROW;
  localparam logic [AW-1:0] LIMIT = AW'(NSW);

  logic [NSW-1:0] stage_q, stage_d, out_q, hit;
  logic           rd_q;
  logic           load;

  assign load = ld_strobe | (wr_valid & wr_load);

  for (genvar i = 0; i < NSW; i++) begin : g_dec
    assign hit[i]     = wr_valid && (wr_addr == AW'(i));
    assign stage_d[i] = hit[i] ? wr_data : stage_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      out_q   <= '0;
      rd_q    <= 1'b0;
    end else begin
      stage_q <= stage_d;
      if (load) out_q <= stage_d;
      rd_q <= (rd_addr < LIMIT) ? out_q[rd_addr] : 1'b0;
    end
  end

  assign sw_en   = out_q;
  assign rd_data = rd_q;
endmodule

// File: rtl/xpt_switch_ctrl_chk.sv
module xpt_switch_ctrl_chk #(
  parameter int NSW = 96,
  parameter int AW  = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_valid,
  input logic [AW-1:0]  wr_addr,
  input logic           wr_data,
  input logic           wr_load,
  input logic           ld_strobe,
  input logic [AW-1:0]  rd_addr,
  input logic           rd_data,
  input logic [NSW-1:0] sw_en,
  input logic [NSW-1:0] stage_q
);
  localparam logic [AW-1:0] LIMIT = AW'(NSW);

  // R2: without any load, the applied rank holds
  a_r2_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_strobe && !(wr_valid && wr_load)) |=> $stable(sw_en));

  // R4: an immediate-load write appears on the output at once
  a_r4_immediate_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_load && wr_addr < LIMIT) |=> sw_en[$past(wr_addr)] == $past(wr_data));

  // R3: a load strobe makes the output equal to the staged rank
  a_r3_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_strobe && !wr_valid) |=> sw_en == stage_q);

  // R6: reserved addresses leave the staging rank alone
  a_r6_reserved_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr >= LIMIT) |=> $stable(stage_q));

  // R8: reserved readback is zero
  a_r8_reserved_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr >= LIMIT) |=> !rd_data);

  // R7: outputs are clear whenever reset is held
  always @(negedge clk) begin
    if (!rst_n) a_r7_reset_clear: assert (sw_en == '0 && stage_q == '0);
  end
endmodule

bind xpt_switch_ctrl xpt_switch_ctrl_chk #(.NSW(NCOL*NROW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .wr_data(wr_data), .wr_load(wr_load), .ld_strobe(ld_strobe),
  .rd_addr(rd_addr), .rd_data(rd_data), .sw_en(sw_en), .stage_q(stage_q)
);

// File: tb/xpt_switch_ctrl_tb.sv
module xpt_switch_ctrl_tb;
  localparam int NSW = 96;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_data = 1'b0, wr_load = 1'b0, ld_strobe = 1'b0;
  logic [6:0] wr_addr = '0, rd_addr = '0;
  logic rd_data;
  logic [NSW-1:0] sw_en;

  logic [NSW-1:0] m_stage = '0, m_out = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  xpt_switch_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_load(wr_load), .ld_strobe(ld_strobe),
    .rd_addr(rd_addr), .rd_data(rd_data), .sw_en(sw_en)
  );

  // op: 0 write, 1 write with immediate load, 2 load strobe, 3 reserved-address write plus strobe
  // entry: op[17:16] addr[15:9] data[8] chk_idx[7:1] chk_exp[0]
  localparam logic [17:0] TBL [14] = '{
    {2'd0, 7'd0,   1'b1, 7'd0,  1'b0},  // R2 staged, not applied
    {2'd0, 7'd95,  1'b1, 7'd95, 1'b0},  // R2
    {2'd2, 7'd0,   1'b0, 7'd95, 1'b1},  // R3 both applied together
    {2'd0, 7'd29,  1'b1, 7'd29, 1'b0},  // R1 row 3 col 5
    {2'd1, 7'd50,  1'b1, 7'd29, 1'b1},  // R4 carries earlier staged bit
    {2'd1, 7'd88,  1'b1, 7'd88, 1'b1},  // R4 its own bit
    {2'd0, 7'd100, 1'b1, 7'd4,  1'b0},  // R6 reserved write
    {2'd0, 7'd127, 1'b1, 7'd31, 1'b0},  // R6
    {2'd2, 7'd0,   1'b0, 7'd4,  1'b0},  // R6 nothing staged by reserved
    {2'd0, 7'd0,   1'b0, 7'd0,  1'b1},  // R2 off staged, still on
    {2'd3, 7'd96,  1'b1, 7'd0,  1'b0},  // R6 load part still acts
    {2'd0, 7'd7,   1'b1, 7'd7,  1'b0},  // R1 row 0 col 7
    {2'd0, 7'd8,   1'b1, 7'd8,  1'b0},  // R1 row 1 col 0
    {2'd2, 7'd0,   1'b0, 7'd8,  1'b1}   // R3
  };

  task automatic check(input string req, input logic [NSW-1:0] act, input logic [NSW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] op, input logic [6:0] a, input logic d);
    wr_valid  = (op != 2'd2);
    wr_addr   = a;
    wr_data   = d;
    wr_load   = (op == 2'd1);
    ld_strobe = (op == 2'd2) || (op == 2'd3);
    @(negedge clk);
    wr_valid = 0; wr_load = 0; ld_strobe = 0;
    if (op != 2'd2 && a < 7'd96) m_stage[a] = d;
    if (op != 2'd0) m_out = m_stage;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R7 reset state", sw_en, '0);
    rst_n = 1;
    @(negedge clk);

    foreach (TBL[i]) begin
      step(TBL[i][17:16], TBL[i][15:9], TBL[i][8]);
      check("R1/R2/R3/R4/R6 table bit", {{(NSW-1){1'b0}}, sw_en[TBL[i][7:1]]}, {{(NSW-1){1'b0}}, TBL[i][0]});
      check("R2/R3/R4/R6 model", sw_en, m_out);
    end

    // R8 readback
    rd_addr = 7'd50; @(negedge clk);
    check("R8 readback on", {{(NSW-1){1'b0}}, rd_data}, {{(NSW-1){1'b0}}, m_out[50]});
    rd_addr = 7'd51; @(negedge clk);
    check("R8 readback off", {{(NSW-1){1'b0}}, rd_data}, '0);
    rd_addr = 7'd110; @(negedge clk);
    check("R8 reserved readback", {{(NSW-1){1'b0}}, rd_data}, '0);

    // R5 all switches on together
    for (int k = 0; k < NSW; k++) step(2'd0, 7'(k), 1'b1);
    check("R5 staged all, nothing new applied", sw_en, m_out);
    step(2'd2, 7'd0, 1'b0);
    check("R5 all on", sw_en, {NSW{1'b1}});

    // R7 async reset drops pending changes
    step(2'd0, 7'd3, 1'b0);
    #1 rst_n = 0;
    #0.5;
    check("R7 async clear", sw_en, '0);
    m_stage = '0; m_out = '0;
    @(negedge clk); rst_n = 1; @(negedge clk);
    step(2'd2, 7'd0, 1'b0);
    check("R7 load after reset", sw_en, '0);
    step(2'd1, 7'd60, 1'b1);
    check("R4 after reset", sw_en, m_out);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule